// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog timer. A slow time-base strobe drives it, normally one pulse per period of a 32 kHz clock, and software controls it through a small write/read register port. Each register ignores any write that does not carry the key value belonging to that register. A stray store therefore cannot arm the watchdog, retune it or feed it. The countdown length is counted in units of UNIT_TICKS strobes (512 by default), so 64 units take about one second.

In single-stage operation the system reset pulse fires as soon as the countdown runs out. The pulse also appears on an external reset pin, with a selectable polarity and its own output enable. In two-stage operation the first expiry raises an interrupt and starts the countdown again. The reset fires only if a second full countdown also runs out without a restart. Software can force a reset at any time through a keyed software-reset register. After a watchdog reset, the watchdog either rearms itself or switches itself off, depending on a mode bit.

The controller has four states. STANDBY means disabled. STAGE_ONE is the first countdown. STAGE_TWO is the second countdown, with the interrupt raised. FIRING drives the reset pulse. The transitions are as follows:
- arm: STANDBY to STAGE_ONE when enabled.
- feed: STAGE_ONE or STAGE_TWO back to STAGE_ONE with a reload.
- bark: STAGE_ONE to STAGE_TWO at the first expiry in two-stage operation.
- bite: STAGE_ONE or STAGE_TWO to FIRING at the final expiry.
- force: STANDBY, STAGE_ONE or STAGE_TWO to FIRING on a software reset.
- disarm: STAGE_ONE or STAGE_TWO to STANDBY when disabled.
- done: FIRING to STAGE_ONE (rearm set and enable still set) or to STANDBY (otherwise) after the pulse.

Top module: `wdog_keyed`

## Requirements
- R1: The mode register is at address 0x00. A write updates it only when wdata[31:24] is 0x22. Its fields, which read back at the same bit positions, are: bit 0 enable, bit 1 external polarity (1 = active high), bit 2 external output enable, bit 3 interrupt enable, bit 4 rearm after a watchdog reset, and bit 6 two-stage operation. All other read bits are 0.
- R2: The length register is at address 0x04. A write is accepted only when wdata[4:0] is 0x08. The count is taken from wdata[15:5] and reads back at those same bits. An accepted write also reloads a running countdown.
- R3: Writing exactly 0x1971 to address 0x08 reloads the countdown to the programmed length. Any other value has no effect.
- R4: In single-stage operation, a countdown of L units with no restart ends in a system reset pulse. The pulse starts about L*UNIT_TICKS strobes after arming and lasts exactly PULSE (16) clocks.
- R5: When two-stage operation and interrupt enable are both set, the first expiry raises irq. The reset pulse follows only after a second full countdown, and irq drops when the pulse starts.
- R6: Once raised, irq stays high until a valid restart write, a disable, or the reset pulse. A valid restart returns the timer to a fresh first-stage countdown.
- R7: Clearing the enable bit stops the countdown and forces irq low. No reset follows from a stopped countdown.
- R8: Writing 0x1209 to address 0x14 starts the PULSE-clock reset on the next clock, whether or not the timer is enabled. Other values have no effect.
- R9: ext_rst_oe equals the external output enable bit. ext_rst equals sys_rst when the polarity bit is 1 and its inverse when the bit is 0.
- R10: After a watchdog reset pulse, the timer starts a new countdown if rearm is set. Otherwise the enable bit clears and reads back as 0.
- R11: After reset, irq, sys_rst and ext_rst_oe are 0, the mode register reads 0 and the length register reads LEN_RST<<5 (0xF800 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe, one clock wide per slow tick |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data including the key |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | First-stage expiry interrupt |
| sys_rst | output | 1 | System reset pulse, active high |
| ext_rst | output | 1 | External reset pin level |
| ext_rst_oe | output | 1 | Output enable for the external reset pin |

## Verification
The hardest situation to reach from the ports is a restart that arrives while the timer is in its second stage. It has to land after the interrupt is raised but before the second countdown runs out, and the bench must then show that a complete new two-stage sequence begins. The bench shortens the time unit to four strobes and holds the strobe high on every clock. That makes the expiry times exact cycle counts. The bench then places the restart write, and a deliberately wrong restart value before it, inside the second-stage window. Expected levels are queued at the cycles derived from the arm and restart edges. The same timing is used to show that a length write issued just before expiry postpones the reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_STANDBY,
        WD_STAGE_ONE,
        WD_STAGE_TWO,
        WD_FIRING
    } wd_state_e;

    typedef struct packed {
        logic dual;
        logic rearm;
        logic irq_en;
        logic ext_en;
        logic ext_hi;
        logic en;
    } wd_mode_t;

    localparam int OFS_MODE  = 'h00;
    localparam int OFS_LEN   = 'h04;
    localparam int OFS_KICK  = 'h08;
    localparam int OFS_SWRST = 'h14;

    localparam logic [7:0]  MODE_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_KEY  = 32'h0000_1971;
    localparam logic [31:0] SWRST_KEY = 32'h0000_1209;

    localparam int LEN_LSB = 5;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int LEN_RST = 1984,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              clr_en,
    output wd_mode_t          mode_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              kick,
    output logic              swrst,
    output logic [31:0]       rdata
);
    localparam int LEN_MSB = LEN_LSB + LEN_W - 1;

    logic hit_mode, hit_len, hit_kick, hit_swrst;
    logic wr_mode, wr_len;

    assign hit_mode  = (addr == ADDR_W'(OFS_MODE));
    assign hit_len   = (addr == ADDR_W'(OFS_LEN));
    assign hit_kick  = (addr == ADDR_W'(OFS_KICK));
    assign hit_swrst = (addr == ADDR_W'(OFS_SWRST));

    assign wr_mode = wr_en && hit_mode && (wdata[31:24] == MODE_KEY);
    assign wr_len  = wr_en && hit_len  && (wdata[4:0] == LEN_KEY);
    assign kick    = wr_len || (wr_en && hit_kick && (wdata == KICK_KEY));
    assign swrst   = wr_en && hit_swrst && (wdata == SWRST_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            len_q  <= LEN_W'(LEN_RST);
        end else begin
            if (wr_mode) begin
                mode_q.en     <= wdata[0];
                mode_q.ext_hi <= wdata[1];
                mode_q.ext_en <= wdata[2];
                mode_q.irq_en <= wdata[3];
                mode_q.rearm  <= wdata[4];
                mode_q.dual   <= wdata[6];
            end
            // a finished non-rearming reset wins over a concurrent write
            if (clr_en) begin
                mode_q.en <= 1'b0;
            end
            if (wr_len) begin
                len_q <= wdata[LEN_MSB:LEN_LSB];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_mode) begin
            rdata[0] = mode_q.en;
            rdata[1] = mode_q.ext_hi;
            rdata[2] = mode_q.ext_en;
            rdata[3] = mode_q.irq_en;
            rdata[4] = mode_q.rearm;
            rdata[6] = mode_q.dual;
        end else if (hit_len) begin
            rdata[LEN_MSB:LEN_LSB] = len_q;
        end
    end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int UNIT_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic unit
);
    localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);

    logic [PW-1:0] pre;

    assign unit = run && tick && (pre == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clear) begin
            pre <= '0;
        end else if (run && tick) begin
            pre <= unit ? '0 : pre + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int PULSE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             two_stage,
    input  logic             rearm,
    input  logic             kick,
    input  logic             swrst,
    input  logic [LEN_W-1:0] len,
    input  logic             unit,
    output wd_state_e        state,
    output logic             load,
    output logic             run,
    output logic             clr_en
);
    localparam int PCW = $clog2(PULSE + 1);
    localparam logic [PCW-1:0] PLAST = PCW'(PULSE - 1);

    wd_state_e        nxt;
    logic [LEN_W-1:0] cnt;
    logic [PCW-1:0]   pcnt;
    logic             expire, pulse_done;

    assign expire     = unit && (cnt <= LEN_W'(1));
    assign pulse_done = (pcnt == PLAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_STANDBY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WD_STANDBY: begin
                if (swrst)   nxt = WD_FIRING;
                else if (en) nxt = WD_STAGE_ONE;
            end
            WD_STAGE_ONE: begin
                if (swrst)       nxt = WD_FIRING;
                else if (!en)    nxt = WD_STANDBY;
                else if (kick)   nxt = WD_STAGE_ONE;
                else if (expire) nxt = two_stage ? WD_STAGE_TWO : WD_FIRING;
            end
            WD_STAGE_TWO: begin
                if (swrst)       nxt = WD_FIRING;
                else if (!en)    nxt = WD_STANDBY;
                else if (kick)   nxt = WD_STAGE_ONE;
                else if (expire) nxt = WD_FIRING;
            end
            WD_FIRING: begin
                if (pulse_done) nxt = (en && rearm) ? WD_STAGE_ONE : WD_STANDBY;
            end
            default: nxt = WD_STANDBY;
        endcase
    end

    always_comb begin
        run    = (state == WD_STAGE_ONE) || (state == WD_STAGE_TWO);
        load   = ((nxt == WD_STAGE_ONE) || (nxt == WD_STAGE_TWO)) &&
                 ((nxt != state) || kick);
        clr_en = (state == WD_FIRING) && pulse_done && !rearm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            if (load)                        cnt <= len;
            else if (unit && cnt != '0)      cnt <= cnt - 1'b1;
            if (state != WD_FIRING)          pcnt <= '0;
            else if (!pulse_done)            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int UNIT_TICKS = 512,
    parameter int LEN_W      = 11,
    parameter int LEN_RST    = 1984,
    parameter int PULSE      = 16,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              sys_rst,
    output logic              ext_rst,
    output logic              ext_rst_oe
);
    wd_mode_t         mode_q;
    logic [LEN_W-1:0] len_q;
    logic             kick, swrst, clr_en, load, run, unit;
    logic             cfg_en;
    wd_state_e        state;

    wdog_regs #(.LEN_W(LEN_W), .LEN_RST(LEN_RST), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .clr_en (clr_en),
        .mode_q (mode_q),
        .len_q  (len_q),
        .kick   (kick),
        .swrst  (swrst),
        .rdata  (rdata)
    );

    wdog_prescale #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .run   (run),
        .tick  (tick),
        .unit  (unit)
    );

    wdog_fsm #(.LEN_W(LEN_W), .PULSE(PULSE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode_q.en),
        .two_stage (mode_q.dual && mode_q.irq_en),
        .rearm     (mode_q.rearm),
        .kick      (kick),
        .swrst     (swrst),
        .len       (len_q),
        .unit      (unit),
        .state     (state),
        .load      (load),
        .run       (run),
        .clr_en    (clr_en)
    );

    assign cfg_en     = mode_q.en;
    assign irq        = (state == WD_STAGE_TWO) && mode_q.en;
    assign sys_rst    = (state == WD_FIRING);
    assign ext_rst_oe = mode_q.ext_en;
    assign ext_rst    = mode_q.ext_hi ? sys_rst : ~sys_rst;

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
    parameter int PULSE  = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              irq,
    input logic              sys_rst,
    input logic              cfg_en
);
    localparam int HW = $clog2(PULSE + 2) + 1;

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= '0;
        else if (sys_rst) hi_run <= hi_run + 1'b1;
        else              hi_run <= '0;
    end

    // R4: each reset pulse is exactly PULSE clocks long
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (hi_run == HW'(PULSE)));

    // R5: interrupt and reset never overlap
    assert_irq_rst_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && sys_rst));

    // R6: without a register write, a raised irq persists until the reset
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> (irq || sys_rst));

    // R7: a disabled watchdog never shows an interrupt
    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !irq);

    // R8: a keyed software reset starts the pulse on the next clock
    assert_swrst_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h14) && wdata == 32'h0000_1209 && !sys_rst)
        |=> sys_rst);

endmodule

bind wdog_keyed wdog_keyed_chk #(.PULSE(PULSE), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .sys_rst (sys_rst),
    .cfg_en  (cfg_en)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;

    localparam int U  = 4;
    localparam int L  = 5;
    localparam int LU = L * U;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sys_rst, ext_rst, ext_rst_oe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wdog_keyed #(.UNIT_TICKS(U)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .irq        (irq),
        .sys_rst    (sys_rst),
        .ext_rst    (ext_rst),
        .ext_rst_oe (ext_rst_oe)
    );

    function automatic logic pick(int s);
        case (s)
            0:       return irq;
            1:       return sys_rst;
            2:       return ext_rst;
            default: return ext_rst_oe;
        endcase
    endfunction

    function automatic string sname(int s);
        case (s)
            0:       return "irq";
            1:       return "sys_rst";
            2:       return "ext_rst";
            default: return "ext_rst_oe";
        endcase
    endfunction

    // monitor: pops expected items as their cycle comes up
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            exp_t it;
            logic got;
            it = exp_q.pop_front();
            got = pick(it.sig);
            checks++;
            if (it.at != cyc) begin
                errors++;
                $display("FAIL %s: %s sample at cycle %0d missed (now %0d), expected %0b",
                         it.req, sname(it.sig), it.at, cyc, it.val);
            end else if (got !== it.val) begin
                errors++;
                $display("FAIL %s: %s at cycle %0d actual %0b expected %0b",
                         it.req, sname(it.sig), cyc, got, it.val);
            end
        end
    end

    task automatic push(int at, int s, logic v, string r);
        exp_t it;
        it.at = at; it.sig = s; it.val = v; it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, output int c);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 c = cyc;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s: read 0x%0h actual 0x%08h expected 0x%08h", r, a, rdata, e);
        end
    endtask

    task automatic now_check(int s, logic v, string r);
        checks++;
        if (pick(s) !== v) begin
            errors++;
            $display("FAIL %s: %s actual %0b expected %0b", r, sname(s), pick(s), v);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, k0, k1, d0, s0, s1, l0, tmp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        now_check(0, 1'b0, "R11");
        now_check(1, 1'b0, "R11");
        now_check(3, 1'b0, "R11");
        rd_check(5'h00, 32'h0, "R11");
        rd_check(5'h04, 32'h0000_F800, "R11");

        // R1 key filtering and field readback
        wr(5'h00, 32'h2100_0017, tmp);
        rd_check(5'h00, 32'h0, "R1");
        wr(5'h00, 32'h2200_0016, tmp);
        rd_check(5'h00, 32'h0000_0016, "R1");
        @(negedge clk);
        now_check(3, 1'b1, "R9");
        now_check(2, 1'b0, "R9");

        // R2 length key filtering
        wr(5'h04, (32'(L) << 5) | 32'h7, tmp);
        rd_check(5'h04, 32'h0000_F800, "R2");
        wr(5'h04, (32'(L) << 5) | 32'h8, tmp);
        rd_check(5'h04, 32'(L) << 5, "R2");

        // R4 single-stage expiry, R9 active-high pin, R10 rearm
        wr(5'h00, 32'h2200_0017, c0);
        push(c0 + LU - 3,  1, 1'b0, "R4");
        push(c0 + LU + 4,  1, 1'b1, "R4");
        push(c0 + LU + 4,  2, 1'b1, "R9");
        push(c0 + LU + 14, 1, 1'b1, "R4");
        push(c0 + LU + 20, 1, 1'b0, "R4");
        push(c0 + 2*LU + 14, 1, 1'b0, "R10");
        push(c0 + 2*LU + 20, 1, 1'b1, "R10");
        drain();
        wait_to(c0 + 2*LU + 36);
        wr(5'h00, 32'h2200_0000, d0);
        push(d0 + 30, 1, 1'b0, "R7");
        drain();

        // R10 no rearm: enable clears after the pulse
        wr(5'h00, 32'h2200_0001, c0);
        push(c0 + LU + 4, 1, 1'b1, "R10");
        push(c0 + LU + 4, 3, 1'b0, "R9");
        drain();
        wait_to(c0 + LU + 22);
        rd_check(5'h00, 32'h0, "R10");

        // R2 length write reloads a running count
        wr(5'h00, 32'h2200_0001, c0);
        wait_to(c0 + LU - 5);
        wr(5'h04, (32'(L) << 5) | 32'h8, l0);
        push(c0 + LU + 4, 1, 1'b0, "R2");
        push(l0 + LU + 4, 1, 1'b1, "R2");
        drain();
        wait_to(l0 + LU + 22);

        // R5 two-stage sequence with active-low pin (R9)
        wr(5'h00, 32'h2200_004D, c0);
        push(c0 + LU - 3,    0, 1'b0, "R5");
        push(c0 + LU + 4,    0, 1'b1, "R5");
        push(c0 + LU + 4,    1, 1'b0, "R5");
        push(c0 + 2*LU - 3,  0, 1'b1, "R6");
        push(c0 + 2*LU + 4,  1, 1'b1, "R5");
        push(c0 + 2*LU + 4,  2, 1'b0, "R9");
        push(c0 + 2*LU + 4,  0, 1'b0, "R5");
        push(c0 + 2*LU + 20, 1, 1'b0, "R5");
        push(c0 + 2*LU + 20, 2, 1'b1, "R9");
        drain();
        wait_to(c0 + 2*LU + 24);

        // R6 / R3 restart during the second stage
        wr(5'h00, 32'h2200_0049, c0);
        wait_to(c0 + LU + 4);
        now_check(0, 1'b1, "R5");
        wr(5'h08, 32'h0000_1970, k0);
        push(k0 + 2, 0, 1'b1, "R3");
        drain();
        wr(5'h08, 32'h0000_1971, k1);
        push(k1 + 2,      0, 1'b0, "R6");
        push(k1 + LU - 3, 0, 1'b0, "R3");
        push(k1 + LU + 4, 0, 1'b1, "R3");
        drain();

        // R7 disable in the second stage
        wr(5'h00, 32'h2200_0048, d0);
        push(d0 + 2,          0, 1'b0, "R7");
        push(d0 + 2*LU + 10,  1, 1'b0, "R7");
        push(d0 + 2*LU + 10,  0, 1'b0, "R7");
        drain();

        // R8 software reset while disabled
        wr(5'h14, 32'h0000_1208, s0);
        push(s0 + 2, 1, 1'b0, "R8");
        drain();
        wr(5'h14, 32'h0000_1209, s1);
        push(s1 + 1,  1, 1'b1, "R8");
        push(s1 + 14, 1, 1'b1, "R8");
        push(s1 + 18, 1, 1'b0, "R8");
        drain();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule